// File: doc/BRIEF.md
# Status-Flag ALU with Branch Condition Evaluator

This block is a small arithmetic slice with a data width of 8 bits by default. On each accepted operation it performs an add, a subtract or a bitwise AND on two operands. The result goes into a result register. Carry, sign, zero and overflow go into a flag register. There are also two flag-only operations. Compare subtracts and test ANDs: both update the flags and leave the result register as it was.

A second function reads the registered flags and decides whether a conditional branch would be taken for a 4-bit condition code. The codes cover three groups. The first group tests a single flag. The second group holds the unsigned orderings and the third the signed orderings, and both are read after a compare of A against B. The decision is combinational from the flag register. A controller can therefore issue a compare in one cycle and act on the branch decision in the next.

Top module: `cc_alu_unit`

## Requirements
- R1: Code 0 (add) with op_valid high loads result with (A + B) mod 2^8 on the next edge and sets flag_c to the carry out of the top bit.
- R2: Code 1 (subtract) loads result with A + ~B + 1. flag_c is the carry out of that sum, so flag_c = 1 means A >= B unsigned (no borrow).
- R3: Code 2 (AND) loads result with A & B and clears flag_c and flag_v.
- R4: After every flag-updating operation, flag_s equals the top bit of the operation's value and flag_z is 1 exactly when all bits of that value are 0.
- R5: flag_v equals the carry into the top bit XOR the carry out of it. For add and subtract this is signed overflow.
- R6: Code 3 (compare) sets the flags exactly as subtract does, and code 4 (test) sets them exactly as AND does. Neither changes result.
- R7: With op_valid low, or with op codes 5 to 7, neither result nor any flag changes.
- R8: Flag-test conditions: 0 taken when Z=1, 1 when Z=0, 2 when C=1, 3 when C=0, 4 when S=0, 5 when S=1, 6 when V=1, 7 when V=0.
- R9: Unsigned conditions after compare A,B: 8 taken when A > B (C & ~Z), 9 when A >= B (C), 10 when A < B (~C), 11 when A <= B (~C | Z).
- R10: Signed conditions after compare A,B: 12 taken when A > B (~(S^V) & ~Z), 13 when A >= B (~(S^V)), 14 when A < B (S^V), 15 when A <= B ((S^V) | Z).
- R11: br_taken depends only on the registered flags and br_cond. An operation accepted in a cycle affects br_taken only after that cycle's clock edge.
- R12: Synchronous active-high reset clears result and all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept the operation on this edge |
| op_code | input | 3 | 0 add, 1 subtract, 2 AND, 3 compare, 4 test, 5-7 no operation |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| br_cond | input | 4 | Branch condition code (R8-R10) |
| result | output | DATA_W | Registered result |
| flag_c | output | 1 | Carry flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| br_taken | output | 1 | Branch decision for br_cond |

## Verification
A flag update and a branch query can fall in the same cycle. This is the case where a controller issues a compare and asks for a branch decision before the compare's flags have settled. The bench provokes it in two steps. First it leaves the flags holding an equal compare. Then, in one cycle, it drives a new unequal compare together with the equal condition. br_taken is sampled before the edge and must show the old flags. It is sampled again a cycle later and must show the new flags. The bench also sweeps compares over sign and magnitude boundaries and judges every condition against unsigned and signed orderings of the operands, computed directly.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_CMP = 3'd3,
        OP_TST = 3'd4,
        OP_RS5 = 3'd5,
        OP_RS6 = 3'd6,
        OP_RS7 = 3'd7
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_ZSET  = 4'd0,
        CC_ZCLR  = 4'd1,
        CC_CSET  = 4'd2,
        CC_CCLR  = 4'd3,
        CC_SCLR  = 4'd4,
        CC_SSET  = 4'd5,
        CC_VSET  = 4'd6,
        CC_VCLR  = 4'd7,
        CC_UGT   = 4'd8,
        CC_UGE   = 4'd9,
        CC_ULT   = 4'd10,
        CC_ULE   = 4'd11,
        CC_SGT   = 4'd12,
        CC_SGE   = 4'd13,
        CC_SLT   = 4'd14,
        CC_SLE   = 4'd15
    } cond_e;

    typedef struct packed {
        logic v;
        logic z;
        logic s;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        K_ARITH = 2'd0,
        K_LOGIC = 2'd1,
        K_NONE  = 2'd2
    } op_kind_e;

    // Classify an operation: which unit produces flags, whether result is written.
    function automatic op_kind_e kind_of(alu_op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_CMP: kind_of = K_ARITH;
            OP_AND, OP_TST:         kind_of = K_LOGIC;
            default:                kind_of = K_NONE;
        endcase
    endfunction

    function automatic logic writes_result(alu_op_e op);
        writes_result = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND);
    endfunction

    function automatic logic is_subtract(alu_op_e op);
        is_subtract = (op == OP_SUB) || (op == OP_CMP);
    endfunction

endpackage

// File: rtl/cc_carry_chain.sv
module cc_carry_chain #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         carry_into_msb,
    output logic         carry_out
);
    logic [W:0] cy;

    assign cy[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ b[i] ^ cy[i];
        assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
    end

    assign carry_into_msb = cy[W-1];
    assign carry_out      = cy[W];
endmodule

// File: rtl/cc_flag_gen.sv
module cc_flag_gen
    import cc_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e         op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    value,
    output flags_t          flags,
    output logic            upd_flags,
    output logic            upd_result
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic         cin;
    logic [W-1:0] arith_sum;
    logic         c_msb_in;
    logic         c_out;
    logic [W-1:0] logic_val;
    op_kind_e     kind;

    assign kind  = kind_of(op);
    assign cin   = is_subtract(op);
    assign b_eff = cin ? ~b : b;

    cc_carry_chain #(.W(W)) u_chain (
        .a              (a),
        .b              (b_eff),
        .cin            (cin),
        .sum            (arith_sum),
        .carry_into_msb (c_msb_in),
        .carry_out      (c_out)
    );

    assign logic_val = a & b;

    always_comb begin
        value = '0;
        flags = '0;
        case (kind)
            K_ARITH: begin
                value   = arith_sum;
                flags.c = c_out;
                flags.v = c_msb_in ^ c_out;
            end
            K_LOGIC: begin
                value   = logic_val;
                flags.c = 1'b0;
                flags.v = 1'b0;
            end
            default: begin
                value = '0;
            end
        endcase
        flags.s = value[MSB];
        flags.z = (value == '0);
    end

    assign upd_flags  = (kind != K_NONE);
    assign upd_result = writes_result(op);
endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
    import cc_pkg::*;
(
    input  flags_t     f,
    input  logic [3:0] cond,
    output logic       taken
);
    logic lt_signed;

    assign lt_signed = f.s ^ f.v;

    always_comb begin
        case (cond_e'(cond))
            CC_ZSET: taken = f.z;
            CC_ZCLR: taken = ~f.z;
            CC_CSET: taken = f.c;
            CC_CCLR: taken = ~f.c;
            CC_SCLR: taken = ~f.s;
            CC_SSET: taken = f.s;
            CC_VSET: taken = f.v;
            CC_VCLR: taken = ~f.v;
            CC_UGT:  taken = f.c & ~f.z;
            CC_UGE:  taken = f.c;
            CC_ULT:  taken = ~f.c;
            CC_ULE:  taken = ~f.c | f.z;
            CC_SGT:  taken = ~lt_signed & ~f.z;
            CC_SGE:  taken = ~lt_signed;
            CC_SLT:  taken = lt_signed;
            CC_SLE:  taken = lt_signed | f.z;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/cc_alu_unit.sv
module cc_alu_unit
    import cc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [3:0]        br_cond,
    output logic [DATA_W-1:0] result,
    output logic              flag_c,
    output logic              flag_s,
    output logic              flag_z,
    output logic              flag_v,
    output logic              br_taken
);
    alu_op_e           op;
    logic [DATA_W-1:0] value;
    flags_t            nxt_flags;
    flags_t            flags_q;
    logic              upd_flags;
    logic              upd_result;
    logic [DATA_W-1:0] result_q;

    assign op = alu_op_e'(op_code);

    cc_flag_gen #(.W(DATA_W)) u_gen (
        .op         (op),
        .a          (opnd_a),
        .b          (opnd_b),
        .value      (value),
        .flags      (nxt_flags),
        .upd_flags  (upd_flags),
        .upd_result (upd_result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '0;
            result_q <= '0;
        end else if (op_valid) begin
            if (upd_flags)  flags_q  <= nxt_flags;
            if (upd_result) result_q <= value;
        end
    end

    cc_cond_eval u_cond (
        .f     (flags_q),
        .cond  (br_cond),
        .taken (br_taken)
    );

    assign result = result_q;
    assign flag_c = flags_q.c;
    assign flag_s = flags_q.s;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
endmodule

// File: rtl/cc_alu_unit_chk.sv
module cc_alu_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [3:0]        br_cond,
    input logic [DATA_W-1:0] result,
    input logic              flag_c,
    input logic              flag_s,
    input logic              flag_z,
    input logic              flag_v,
    input logic              br_taken
);
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] and_w;
    logic              wr_op;
    logic              logic_op;
    logic              idle;

    assign sum_w    = opnd_a + opnd_b;
    assign and_w    = opnd_a & opnd_b;
    assign wr_op    = op_valid && (op_code <= 3'd2);
    assign logic_op = op_valid && (op_code == 3'd2 || op_code == 3'd4);
    assign idle     = !op_valid || (op_code > 3'd4);

    AST_ADD_VALUE: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == 3'd0 |=> result == $past(sum_w)); // R1

    AST_AND_VALUE: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == 3'd2 |=> result == $past(and_w)); // R3

    AST_LOGIC_CLEARS_CV: assert property (@(posedge clk) disable iff (rst)
        logic_op |=> !flag_c && !flag_v); // R3

    AST_ZERO_SIGN_TRACK: assert property (@(posedge clk) disable iff (rst)
        wr_op |=> (flag_z == (result == '0)) && (flag_s == result[DATA_W-1])); // R4

    AST_FLAG_ONLY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op_code == 3'd3 || op_code == 3'd4) |=> $stable(result)); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        idle |=> $stable(result) && $stable({flag_c, flag_s, flag_z, flag_v})); // R7

    AST_EQ_TRACKS_Z: assert property (@(posedge clk) disable iff (rst)
        br_cond == 4'd0 |-> br_taken == flag_z); // R8

    AST_UGE_TRACKS_C: assert property (@(posedge clk) disable iff (rst)
        br_cond == 4'd9 |-> br_taken == flag_c); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> result == '0 && !flag_c && !flag_s && !flag_z && !flag_v); // R12
endmodule

bind cc_alu_unit cc_alu_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .br_cond  (br_cond),
    .result   (result),
    .flag_c   (flag_c),
    .flag_s   (flag_s),
    .flag_z   (flag_z),
    .flag_v   (flag_v),
    .br_taken (br_taken)
);

// File: tb/cc_alu_unit_tb_top.sv
module cc_alu_unit_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         op_valid;
    logic [2:0]   op_code;
    logic [W-1:0] opnd_a;
    logic [W-1:0] opnd_b;
    logic [3:0]   br_cond;
    logic [W-1:0] result;
    logic         flag_c, flag_s, flag_z, flag_v, br_taken;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    cc_alu_unit #(.DATA_W(W)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .br_cond(br_cond),
        .result(result), .flag_c(flag_c), .flag_s(flag_s),
        .flag_z(flag_z), .flag_v(flag_v), .br_taken(br_taken)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one operation for one cycle; returns at the following negedge.
    task automatic issue(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // Independent reference of flags for add/sub/and.
    function automatic logic [W+3:0] ref_op(input int kind, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0]   full;
        logic [W-1:0] r;
        logic c, v;
        if (kind == 2) begin
            r = a & b; c = 1'b0; v = 1'b0;
        end else if (kind == 1) begin
            full = {1'b0, a} + {1'b0, ~b} + 1;
            r = full[W-1:0]; c = full[W];
            v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
        end else begin
            full = {1'b0, a} + {1'b0, b};
            r = full[W-1:0]; c = full[W];
            v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
        end
        ref_op = {v, (r == '0), r[W-1], c, r};
    endfunction

    task automatic check_flags(string req, logic [W+3:0] e);
        check(req, flag_c, e[W],   "flag_c");
        check(req, flag_s, e[W+1], "flag_s");
        check(req, flag_z, e[W+2], "flag_z");
        check(req, flag_v, e[W+3], "flag_v");
    endtask

    task automatic query(input logic [3:0] cond, input logic exp, string req);
        br_cond = cond;
        #1;
        check(req, br_taken, exp, $sformatf("cond %0d", cond));
    endtask

    task automatic t_reset;
        check("R12", result, 0, "result");
        check_flags("R12", '0);
    endtask

    task automatic t_arith(input int kind, input logic [W-1:0] a, input logic [W-1:0] b, string req);
        logic [W+3:0] e;
        e = ref_op(kind, a, b);
        issue(kind[2:0], a, b);
        check(req, result, e[W-1:0], "result");
        check_flags(req, e);
        check("R5", flag_v, e[W+3], "overflow");
    endtask

    task automatic t_flag_tests(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W+3:0] e;
        e = ref_op(0, a, b);
        issue(3'd0, a, b);
        query(4'd0, e[W+2], "R8");   query(4'd1, !e[W+2], "R8");
        query(4'd2, e[W],   "R8");   query(4'd3, !e[W],   "R8");
        query(4'd4, !e[W+1], "R8");  query(4'd5, e[W+1],  "R8");
        query(4'd6, e[W+3], "R8");   query(4'd7, !e[W+3], "R8");
    endtask

    task automatic t_compare(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] keep;
        keep = result;
        issue(3'd3, a, b);
        check("R6", result, keep, "compare keeps result");
        check_flags("R6", ref_op(1, a, b));
        query(4'd8,  a > b,  "R9");  query(4'd9,  a >= b, "R9");
        query(4'd10, a < b,  "R9");  query(4'd11, a <= b, "R9");
        query(4'd12, $signed(a) >  $signed(b), "R10");
        query(4'd13, $signed(a) >= $signed(b), "R10");
        query(4'd14, $signed(a) <  $signed(b), "R10");
        query(4'd15, $signed(a) <= $signed(b), "R10");
    endtask

    task automatic t_test_op(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] keep;
        keep = result;
        issue(3'd4, a, b);
        check("R6", result, keep, "test keeps result");
        check_flags("R6", ref_op(2, a, b));
    endtask

    task automatic t_idle;
        logic [W-1:0] keep_r;
        logic [3:0]   keep_f;
        keep_r = result; keep_f = {flag_v, flag_z, flag_s, flag_c};
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd1; opnd_a = 8'h01; opnd_b = 8'h01;
        @(negedge clk);
        check("R7", result, keep_r, "no valid result");
        check("R7", {flag_v, flag_z, flag_s, flag_c}, keep_f, "no valid flags");
        for (int k = 5; k < 8; k++) begin
            issue(k[2:0], 8'h00, 8'h00);
            check("R7", result, keep_r, "reserved op result");
            check("R7", {flag_v, flag_z, flag_s, flag_c}, keep_f, "reserved op flags");
        end
    endtask

    task automatic t_same_cycle;
        issue(3'd3, 8'h5A, 8'h5A);       // leaves Z=1
        @(negedge clk);
        br_cond = 4'd0;
        op_valid = 1'b1; op_code = 3'd3; opnd_a = 8'h01; opnd_b = 8'h02;
        #1;
        check("R11", br_taken, 1'b1, "old flags before edge");
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        check("R11", br_taken, 1'b0, "new flags after edge");
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = '0; opnd_a = '0; opnd_b = '0; br_cond = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_arith(0, 8'h12, 8'h34, "R1");
        t_arith(0, 8'hF0, 8'h20, "R1");  // carry out
        t_arith(0, 8'h70, 8'h10, "R5");  // positive overflow
        t_arith(0, 8'h80, 8'h80, "R4");  // zero result with carry and overflow
        t_arith(1, 8'hF0, 8'h14, "R2");  // 0xDC, C=1 S=1 Z=0 V=0
        t_arith(1, 8'h14, 8'hF0, "R2");  // borrow
        t_arith(1, 8'h80, 8'h01, "R5");  // negative overflow
        t_arith(2, 8'hCC, 8'hAA, "R3");
        t_arith(2, 8'h0F, 8'hF0, "R4");  // zero
        t_test_op(8'h80, 8'hFF);
        t_test_op(8'h0F, 8'h30);
        t_flag_tests(8'h7F, 8'h01);
        t_flag_tests(8'hFF, 8'h01);
        t_flag_tests(8'h01, 8'h02);
        t_compare(8'h05, 8'h05);
        t_compare(8'h80, 8'h7F);
        t_compare(8'h7F, 8'h80);
        t_compare(8'h00, 8'hFF);
        t_compare(8'hF0, 8'h14);
        t_compare(8'h03, 8'h09);
        t_idle();
        t_same_cycle();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
            wait (done);
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule